// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a finite impulse response filter with fixed coefficients and no multipliers. It keeps the most recent `TAPS` input samples in a window. For each output it walks through the sample bits one bit-plane per clock, starting at the least significant bit. The bits of one plane, taken across all taps, form an address into a table of precomputed coefficient sums. A shift-accumulator adds each table word into a running total with the weight of its bit position. After `DATA_W` such cycles the total is the exact dot product of the coefficients and the window.

To keep the tables small, the taps are split into groups of `GROUP_TAPS`. Each group has its own table of `2^GROUP_TAPS` words, built at elaboration from the coefficient parameter, and its own accumulator. A final adder combines the group totals into the registered output. A parameter selects unsigned arithmetic or two's-complement arithmetic for both data and coefficients.

The surrounding system presents one sample every `SAMPLE_RATIO` clocks, with `SAMPLE_RATIO >= DATA_W`. The datapath is idle for the clocks that are left over.

Top module: `da_fir`

## Requirements
- R1: While `rstn` is low, all registers are cleared asynchronously, so `datao` is 0 and `datao_valid` is 0. All registers change only on the rising edge of `clk`.
- R2: A sample is accepted on a rising edge where `datai_en` is high and the block can take a sample (see R7 and R8). `datao_valid` then goes high after the (`DATA_W`+1)-th following rising edge and stays high for exactly one clock.
- R3: In unsigned mode (`SIGNED_MODE`=0), `datao` equals the sum over k of c_k·x[n-k]. Here x[n] is the newest accepted sample, tap k multiplies the sample accepted k samples earlier, and c_k is the unsigned field `COEFS[k*COEF_W +: COEF_W]`.
- R4: In signed mode (`SIGNED_MODE`=1), samples, coefficients and `datao` are all two's complement. The bit-plane of the sample sign bit carries negative weight.
- R5: `datao` is `DATA_W+COEF_W+ceil(log2(TAPS))` bits wide and holds the exact result with no rounding or truncation, including when every sample is at its most positive or most negative value.
- R6: After reset the sample window holds zeros. Outputs computed before `TAPS` samples have arrived use 0 for the taps that have not been filled.
- R7: A `datai_en` pulse that arrives during a computation, before its last bit-plane cycle, is ignored. It produces no result and does not enter the window.
- R8: `datai_en` on the last bit-plane cycle of a computation is accepted. Samples spaced exactly `DATA_W` clocks apart are therefore all processed.
- R9: `datao` keeps its value on every clock in which `datao_valid` is low.
- R10: The result does not depend on how the taps are split into groups. One group of `TAPS`, several groups of `GROUP_TAPS`, and groups of a single tap all give the same output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstn | input | 1 | Asynchronous reset, active low |
| datai_en | input | 1 | Sample strobe, active high |
| datai | input | DATA_W | Input sample |
| datao_valid | output | 1 | One-clock pulse marking a new result |
| datao | output | DATA_W+COEF_W+ceil(log2(TAPS)) | Filter result, full precision |

## Verification
The bench runs three copies side by side: unsigned with two groups, unsigned with one group, and signed with single-tap groups. It sweeps every input code through the window, so a table word built from the wrong tap order, or a wrong group split, would show up as a wrong sum in one copy only. Sign-bit samples at both extremes go after the negative weight of the last bit-plane: a design that adds that plane instead of subtracting it is off by twice its weight. Samples arrive both at the minimal spacing and too early. A block that refuses the last-cycle sample would drop a result, and one that takes an early sample would emit an extra result or shift the window by one. The first outputs after reset expose a window that is not cleared.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

   // full-precision result width for the filter
   function automatic int fir_out_w(input int data_w, input int coef_w, input int taps);
      return data_w + coef_w + $clog2(taps);
   endfunction

   // table word width for a group of q taps (one spare bit keeps unsigned sums positive)
   function automatic int lut_w(input int coef_w, input int q);
      return coef_w + $clog2(q) + 1;
   endfunction

   // width of the bit-plane index
   function automatic int bit_idx_w(input int data_w);
      return (data_w > 1) ? $clog2(data_w) : 1;
   endfunction

endpackage

// File: rtl/da_fir_ctrl.sv
module da_fir_ctrl import da_fir_pkg::*; #(
   parameter  int DATA_W = 4,
   localparam int BW     = bit_idx_w(DATA_W)
) (
   input  logic          clk,
   input  logic          rstn,
   input  logic          start_req,
   output logic          accept,
   output logic          compute,
   output logic [BW-1:0] bit_idx,
   output logic          done
);

   localparam logic [BW-1:0] LAST = BW'(DATA_W - 1);

   logic active;
   logic last;

   assign last    = active && (bit_idx == LAST);
   assign accept  = start_req && (!active || last);
   assign compute = active;

   always_ff @(posedge clk or negedge rstn) begin
      if (!rstn) begin
         active  <= 1'b0;
         bit_idx <= '0;
         done    <= 1'b0;
      end else begin
         done <= last;
         if (accept) begin
            active  <= 1'b1;
            bit_idx <= '0;
         end else if (last) begin
            active  <= 1'b0;
            bit_idx <= '0;
         end else if (active) begin
            bit_idx <= bit_idx + 1'b1;
         end
      end
   end

   // R2
   bit_range_chk: assert property (@(posedge clk) disable iff (!rstn)
      active |-> (bit_idx <= LAST));

   // R7
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstn)
      (active && !last) |=> (active && bit_idx == $past(bit_idx) + 1'b1));

endmodule

// File: rtl/da_fir_window.sv
module da_fir_window #(
   parameter int DATA_W = 4,
   parameter int TAPS   = 4
) (
   input  logic              clk,
   input  logic              rstn,
   input  logic              load,
   input  logic              shift,
   input  logic [DATA_W-1:0] din,
   output logic [TAPS-1:0]   plane
);

   logic [DATA_W-1:0] taps_q [TAPS];

   function automatic logic [DATA_W-1:0] rot(input logic [DATA_W-1:0] v);
      return {v[0], v[DATA_W-1:1]};
   endfunction

   always_ff @(posedge clk or negedge rstn) begin
      if (!rstn) begin
         for (int k = 0; k < TAPS; k++) taps_q[k] <= '0;
      end else if (load) begin
         // on the final bit-plane the rotation restores each word before it moves down
         taps_q[0] <= din;
         for (int k = 1; k < TAPS; k++)
            taps_q[k] <= shift ? rot(taps_q[k-1]) : taps_q[k-1];
      end else if (shift) begin
         for (int k = 0; k < TAPS; k++) taps_q[k] <= rot(taps_q[k]);
      end
   end

   for (genvar k = 0; k < TAPS; k++) begin : g_plane
      assign plane[k] = taps_q[k][0];
   end

endmodule

// File: rtl/da_fir_group.sv
module da_fir_group import da_fir_pkg::*; #(
   parameter  int   DATA_W      = 4,
   parameter  int   COEF_W      = 4,
   parameter  int   GROUP_TAPS  = 2,
   parameter  int   OUT_W       = 10,
   parameter  bit   SIGNED_MODE = 1'b0,
   parameter  logic [GROUP_TAPS*COEF_W-1:0] GCOEFS = '0,
   localparam int   LW          = lut_w(COEF_W, GROUP_TAPS),
   localparam int   DEPTH       = 1 << GROUP_TAPS,
   localparam int   BW          = bit_idx_w(DATA_W)
) (
   input  logic                  clk,
   input  logic                  rstn,
   input  logic                  compute,
   input  logic [BW-1:0]         bit_idx,
   input  logic [GROUP_TAPS-1:0] addr,
   output logic [OUT_W-1:0]      acc
);

   localparam logic [BW-1:0] MSB_IDX = BW'(DATA_W - 1);

   function automatic logic [LW-1:0] rom_word(input int unsigned a);
      logic [LW-1:0]     s;
      logic [COEF_W-1:0] c;
      s = '0;
      for (int j = 0; j < GROUP_TAPS; j++) begin
         c = GCOEFS[j*COEF_W +: COEF_W];
         if (a[j]) s = s + {{(LW-COEF_W){SIGNED_MODE & c[COEF_W-1]}}, c};
      end
      return s;
   endfunction

   logic [LW-1:0] rom [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_rom
      localparam logic [LW-1:0] WORD = rom_word(a);
      assign rom[a] = WORD;
   end

   logic [LW-1:0]    word;
   logic [OUT_W-1:0] term;

   always_comb begin
      word = rom[addr];
      term = {{(OUT_W-LW){word[LW-1]}}, word} << bit_idx;
   end

   if (SIGNED_MODE) begin : g_signed
      always_ff @(posedge clk or negedge rstn) begin
         if (!rstn)                    acc <= '0;
         else if (compute) begin
            if (bit_idx == '0)         acc <= term;
            else if (bit_idx == MSB_IDX) acc <= acc - term;
            else                       acc <= acc + term;
         end
      end
   end else begin : g_unsigned
      always_ff @(posedge clk or negedge rstn) begin
         if (!rstn)                    acc <= '0;
         else if (compute) begin
            if (bit_idx == '0)         acc <= term;
            else                       acc <= acc + term;
         end
      end
   end

endmodule

// File: rtl/da_fir.sv
module da_fir import da_fir_pkg::*; #(
   parameter  int   DATA_W       = 4,
   parameter  int   COEF_W       = 4,
   parameter  int   TAPS         = 4,
   parameter  int   GROUP_TAPS   = 2,
   parameter  int   SAMPLE_RATIO = 6,
   parameter  bit   SIGNED_MODE  = 1'b0,
   parameter  logic [TAPS*COEF_W-1:0] COEFS = {4'd2, 4'd9, 4'd15, 4'd5},
   localparam int   OUT_W        = fir_out_w(DATA_W, COEF_W, TAPS)
) (
   input  logic              clk,
   input  logic              rstn,
   input  logic              datai_en,
   input  logic [DATA_W-1:0] datai,
   output logic              datao_valid,
   output logic [OUT_W-1:0]  datao
);

   localparam int NG = TAPS / GROUP_TAPS;
   localparam int BW = bit_idx_w(DATA_W);

   if (DATA_W < 2) begin : g_bad_width
      $error("da_fir: DATA_W must be at least 2");
   end
   if (TAPS < 2) begin : g_bad_taps
      $error("da_fir: TAPS must be at least 2");
   end
   if (GROUP_TAPS < 1 || (TAPS % GROUP_TAPS) != 0) begin : g_bad_group
      $error("da_fir: GROUP_TAPS must divide TAPS");
   end
   if (SAMPLE_RATIO < DATA_W) begin : g_bad_ratio
      $error("da_fir: SAMPLE_RATIO must be at least DATA_W");
   end

   logic          accept;
   logic          compute;
   logic [BW-1:0] bit_idx;
   logic          done;
   logic [TAPS-1:0] plane;
   logic [OUT_W-1:0] gacc [NG];
   logic [OUT_W-1:0] total;

   da_fir_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rstn      (rstn),
      .start_req (datai_en),
      .accept    (accept),
      .compute   (compute),
      .bit_idx   (bit_idx),
      .done      (done)
   );

   da_fir_window #(.DATA_W(DATA_W), .TAPS(TAPS)) u_window (
      .clk   (clk),
      .rstn  (rstn),
      .load  (accept),
      .shift (compute),
      .din   (datai),
      .plane (plane)
   );

   for (genvar g = 0; g < NG; g++) begin : g_grp
      da_fir_group #(
         .DATA_W      (DATA_W),
         .COEF_W      (COEF_W),
         .GROUP_TAPS  (GROUP_TAPS),
         .OUT_W       (OUT_W),
         .SIGNED_MODE (SIGNED_MODE),
         .GCOEFS      (COEFS[g*GROUP_TAPS*COEF_W +: GROUP_TAPS*COEF_W])
      ) u_group (
         .clk     (clk),
         .rstn    (rstn),
         .compute (compute),
         .bit_idx (bit_idx),
         .addr    (plane[g*GROUP_TAPS +: GROUP_TAPS]),
         .acc     (gacc[g])
      );
   end

   always_comb begin
      total = '0;
      for (int g = 0; g < NG; g++) total = total + gacc[g];
   end

   always_ff @(posedge clk or negedge rstn) begin
      if (!rstn) begin
         datao_valid <= 1'b0;
         datao       <= '0;
      end else begin
         datao_valid <= done;
         if (done) datao <= total;
      end
   end

   // R2
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstn)
      datao_valid |=> !datao_valid);

   // R9
   hold_between_chk: assert property (@(posedge clk) disable iff (!rstn)
      !datao_valid |-> $stable(datao));

endmodule

// File: tb/da_fir_test.sv
`timescale 1ns/1ps
module da_fir_test;

   localparam int D  = 4;
   localparam int C  = 4;
   localparam int T  = 4;
   localparam int SR = 6;
   localparam int OW = D + C + $clog2(T);

   // unsigned coefficients c0..c3 = 5,15,9,2 ; signed c0..c3 = -8,7,-8,-8
   localparam logic [T*C-1:0] CU = {4'd2, 4'd9, 4'd15, 4'd5};
   localparam logic [T*C-1:0] CS = 16'h8878;

   logic clk = 1'b0;
   logic rstn = 1'b0;
   logic datai_en = 1'b0;
   logic [D-1:0] datai = '0;
   logic v_u, v_o, v_s;
   logic [OW-1:0] o_u, o_o, o_s;

   always #4 clk = ~clk;

   da_fir #(.DATA_W(D), .COEF_W(C), .TAPS(T), .GROUP_TAPS(2), .SAMPLE_RATIO(SR),
            .SIGNED_MODE(1'b0), .COEFS(CU)) uut (
      .clk(clk), .rstn(rstn), .datai_en(datai_en), .datai(datai),
      .datao_valid(v_u), .datao(o_u));

   da_fir #(.DATA_W(D), .COEF_W(C), .TAPS(T), .GROUP_TAPS(4), .SAMPLE_RATIO(SR),
            .SIGNED_MODE(1'b0), .COEFS(CU)) uut_one (
      .clk(clk), .rstn(rstn), .datai_en(datai_en), .datai(datai),
      .datao_valid(v_o), .datao(o_o));

   da_fir #(.DATA_W(D), .COEF_W(C), .TAPS(T), .GROUP_TAPS(1), .SAMPLE_RATIO(SR),
            .SIGNED_MODE(1'b1), .COEFS(CS)) uut_sgn (
      .clk(clk), .rstn(rstn), .datai_en(datai_en), .datai(datai),
      .datao_valid(v_s), .datao(o_s));

   typedef struct { int cyc; int eu; int es; } exp_t;
   exp_t q[$];

   int checks = 0;
   int fails  = 0;
   int ecount = 0;
   int last_acc = -1000;
   int hu [T];
   int hs [T];
   string tag = "R1";
   bit mon_on = 1'b0;
   bit finished = 1'b0;
   logic [OW-1:0] prev_u, prev_o, prev_s;

   always @(posedge clk) ecount <= ecount + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, ecount);
      end
   endtask

   function automatic int coef_u(int k);
      return int'(CU[k*C +: C]);
   endfunction
   function automatic int coef_s(int k);
      int v = int'(CS[k*C +: C]);
      return (v >= 8) ? v - 16 : v;
   endfunction

   // called at a negedge; the sample is seen at the next rising edge
   task automatic send(input logic [D-1:0] x, input int gap);
      int nxt = ecount + 1;
      exp_t e;
      datai    = x;
      datai_en = 1'b1;
      if (nxt - last_acc >= D) begin
         last_acc = nxt;
         for (int k = T-1; k > 0; k--) begin hu[k] = hu[k-1]; hs[k] = hs[k-1]; end
         hu[0] = int'(x);
         hs[0] = (int'(x) >= 8) ? int'(x) - 16 : int'(x);
         e.cyc = nxt + D + 1;
         e.eu = 0; e.es = 0;
         for (int k = 0; k < T; k++) begin
            e.eu += coef_u(k) * hu[k];
            e.es += coef_s(k) * hs[k];
         end
         q.push_back(e);
      end
      @(negedge clk);
      datai_en = 1'b0;
      for (int i = 1; i < gap; i++) @(negedge clk);
   endtask

   // output monitor, sampling at the falling edge
   always @(negedge clk) begin
      if (mon_on && !finished) begin
         bit due;
         due = (q.size() > 0) && (q[0].cyc == ecount);
         chk(v_u == due, "R2", int'(v_u), int'(due));
         chk(v_o == due, "R2", int'(v_o), int'(due));
         chk(v_s == due, "R2", int'(v_s), int'(due));
         if (due) begin
            chk(int'(o_u) == q[0].eu, (tag == "R1") ? "R3" : tag, int'(o_u), q[0].eu);
            chk(int'(o_o) == q[0].eu, "R10", int'(o_o), q[0].eu);
            chk(int'($signed(o_s)) == q[0].es, "R4", int'($signed(o_s)), q[0].es);
            void'(q.pop_front());
         end
         if (!v_u) chk(o_u == prev_u, "R9", int'(o_u), int'(prev_u));
         if (!v_s) chk(o_s == prev_s, "R9", int'(o_s), int'(prev_s));
         if (!v_o) chk(o_o == prev_o, "R9", int'(o_o), int'(prev_o));
      end
      prev_u = o_u; prev_o = o_o; prev_s = o_s;
   end

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      for (int k = 0; k < T; k++) begin hu[k] = 0; hs[k] = 0; end
      repeat (3) @(negedge clk);
      // R1: outputs cleared while reset is held
      chk(v_u == 1'b0 && v_o == 1'b0 && v_s == 1'b0, "R1", int'(v_u | v_o | v_s), 0);
      chk(o_u == '0 && o_o == '0 && o_s == '0, "R1", int'(o_u | o_o | o_s), 0);
      rstn = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;
      // R6: the first results use a zero-filled window
      tag = "R6";
      send(4'd1, SR);
      send(4'd3, SR);
      // R3: every code passes through every tap position
      tag = "R3";
      for (int x = 0; x < 16; x++) send(4'(x), SR);
      for (int x = 15; x >= 0; x--) send(4'(x), SR + 1);
      // R5: extreme magnitudes on every tap
      tag = "R5";
      for (int i = 0; i < 5; i++) send(4'hF, SR);
      for (int i = 0; i < 5; i++) send(4'h8, SR);
      for (int i = 0; i < 5; i++) send(4'h7, SR);
      // R8: minimal spacing, the sample arrives on the last bit-plane cycle
      tag = "R8";
      for (int i = 0; i < 8; i++) send(4'(3 * i + 1), D);
      // R7: samples arriving mid-computation are dropped
      tag = "R7";
      send(4'd9, 2);
      send(4'd6, 2);
      send(4'd12, 1);
      send(4'd5, 3);
      send(4'd10, SR);
      send(4'd2, SR);
      // mixed stream with varied spacing
      tag = "R3";
      for (int i = 0; i < 60; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         send(lfsr[3:0], 2 + int'(lfsr[7:5]));
      end
      repeat (D + 4) @(negedge clk);
      chk(q.size() == 0, "R2", q.size(), 0);
      summary();
   end

endmodule